// File: doc/BRIEF.md
# Low-Power Entry and Wake Controller

This block sits beside a processor core and decides how the core enters and leaves its low-power states. The core sends single-cycle pulses for a wait-for-interrupt or a wait-for-event request. The controller then raises a sleep indication, or a deep-sleep indication, and holds it until a qualifying wake condition arrives. It then emits a one-cycle wake pulse and drops the sleep indication on the following cycle.

Events come from a send-event pulse, an external event input, or an interrupt that newly becomes pending while the pend-event control bit is set. An event that arrives while the core is not waiting for one is stored in a one-bit latch. The next wait-for-event consumes the latch and returns without sleeping.

A three-field control register selects three behaviours: ordinary or deep sleep, whether disabled interrupts may wake the core, and automatic re-entry into sleep when the core returns from its last active handler. Only privileged accesses may reach the register.

Top module: `lp_wake_ctrl`

## Requirements
- R1: After reset the control register reads 0, and `sleep_o`, `deep_o` and `wake_o` are all low.
- R2: A privileged write sets only the control fields: bit 1 is sleep-on-return, bit 2 is deep-sleep select and bit 4 is pend-event. A privileged read returns those bits in place, and every other bit reads 0 whatever was written.
- R3: A write with `reg_priv_i` low leaves the register unchanged. A read with `reg_priv_i` low returns 0 and raises `reg_err_o` in the same cycle.
- R4: A `wfi_i` or `wfe_i` pulse while running raises `sleep_o` after the next clock edge. `deep_o` is high while asleep exactly when bit 2 is set.
- R5: While in wait-for-interrupt with bit 4 clear, events do not wake the core and a disabled interrupt becoming pending does not wake it. An enabled interrupt becoming pending does wake it.
- R6: With bit 4 set, an interrupt that becomes pending wakes a wait-for-interrupt or wait-for-event even when it is disabled. It also raises an event.
- R7: A wait-for-event is woken by `sev_i`, by `ext_evt_i`, or by an enabled interrupt becoming pending.
- R8: An event that arrives while no wait-for-event is in progress is latched. The next `wfe_i` clears the latch and the core stays awake. A further `wfe_i` then sleeps.
- R9: When a wake condition is seen at a clock edge, `wake_o` is high for exactly the following cycle with `sleep_o` still high. Both `sleep_o` and `deep_o` are low one cycle after that.
- R10: Wake detection uses the 0-to-1 change of a pending bit. A pending bit held high, or falling, does not wake the core.
- R11: With bit 1 set, a `handler_ret_i` pulse while running re-enters wait-for-interrupt sleep. With bit 1 clear, the pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_rd_i | input | 1 | Control register read strobe |
| reg_priv_i | input | 1 | Access is privileged |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data (combinational) |
| reg_err_o | output | 1 | Unprivileged read error |
| wfi_i | input | 1 | Wait-for-interrupt request pulse |
| wfe_i | input | 1 | Wait-for-event request pulse |
| sev_i | input | 1 | Send-event pulse |
| ext_evt_i | input | 1 | External event pulse |
| handler_ret_i | input | 1 | Return from last active handler pulse |
| irq_pend_i | input | N_IRQ | Interrupt pending vector |
| irq_en_i | input | N_IRQ | Interrupt enable vector |
| sleep_o | output | 1 | Core is in a low-power state |
| deep_o | output | 1 | Low-power state is deep sleep |
| wake_o | output | 1 | Single-cycle wake pulse |

## Verification
The bench builds the block with its defaults, 32 interrupts and a 32-bit data path. This lets the disabled-interrupt and enabled-interrupt cases use separate lines (3, 5, 7, 9) in a single vector. A full-width write of all ones shows that every reserved bit reads as zero. The default width also means the or-reduction over the rising-edge vector is exercised at its real size rather than a trimmed one.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_WFI, ST_WFE, ST_WAKE} lpw_state_e;

  localparam int unsigned BIT_EXIT = 1;
  localparam int unsigned BIT_DEEP = 2;
  localparam int unsigned BIT_PEND = 4;
  localparam int unsigned MIN_DATA_W = BIT_PEND + 1;

  typedef struct packed {
    logic pend_evt;
    logic deep;
    logic exit_slp;
  } lpw_ctrl_t;
endpackage

// File: rtl/lpw_ctrl_reg.sv
module lpw_ctrl_reg
  import lpw_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              priv_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output lpw_ctrl_t         ctrl_o
);
  lpw_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_i && priv_i) begin
      ctrl_q.exit_slp <= wdata_i[BIT_EXIT];
      ctrl_q.deep     <= wdata_i[BIT_DEEP];
      ctrl_q.pend_evt <= wdata_i[BIT_PEND];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i && priv_i) begin
      rdata_o[BIT_EXIT] = ctrl_q.exit_slp;
      rdata_o[BIT_DEEP] = ctrl_q.deep;
      rdata_o[BIT_PEND] = ctrl_q.pend_evt;
    end
  end

  assign err_o  = rd_i && !priv_i;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/lpw_pend_detect.sv
module lpw_pend_detect #(
  parameter int unsigned N_IRQ = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] pend_i,
  input  logic [N_IRQ-1:0] en_i,
  input  logic             pend_evt_i,
  output logic             irq_wake_o,
  output logic             pend_evt_o
);
  logic [N_IRQ-1:0] pend_q;
  logic [N_IRQ-1:0] rise;
  logic [N_IRQ-1:0] qual;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_i;
  end

  for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
    assign rise[g] = pend_i[g] && !pend_q[g];
    // disabled lines qualify only when pend-event is set
    assign qual[g] = rise[g] && (en_i[g] || pend_evt_i);
  end

  assign irq_wake_o = |qual;
  assign pend_evt_o = pend_evt_i && (|rise);
endmodule

// File: rtl/lpw_seq.sv
module lpw_seq
  import lpw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wfi_i,
  input  logic       wfe_i,
  input  logic       ret_i,
  input  logic       exit_en_i,
  input  logic       deep_en_i,
  input  logic       evt_i,
  input  logic       irq_wake_i,
  output logic       sleep_o,
  output logic       deep_o,
  output logic       wake_o,
  output logic       latch_o
);
  lpw_state_e state_q, state_d;
  logic       latch_q, latch_d;

  always_comb begin
    state_d = state_q;
    latch_d = latch_q;
    if (evt_i && state_q != ST_WFE) latch_d = 1'b1;
    unique case (state_q)
      ST_RUN: begin
        if (wfi_i) begin
          state_d = ST_WFI;
        end else if (wfe_i) begin
          // a pending or simultaneous event returns at once
          if (latch_q || evt_i) latch_d = 1'b0;
          else                  state_d = ST_WFE;
        end else if (ret_i && exit_en_i) begin
          state_d = ST_WFI;
        end
      end
      ST_WFI:  if (irq_wake_i)          state_d = ST_WAKE;
      ST_WFE:  if (evt_i || irq_wake_i) state_d = ST_WAKE;
      ST_WAKE: state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      latch_q <= 1'b0;
    end else begin
      state_q <= state_d;
      latch_q <= latch_d;
    end
  end

  assign sleep_o = state_q != ST_RUN;
  assign deep_o  = sleep_o && deep_en_i;
  assign wake_o  = state_q == ST_WAKE;
  assign latch_o = latch_q;
endmodule

// File: rtl/lp_wake_ctrl.sv
module lp_wake_ctrl
  import lpw_pkg::*;
#(
  parameter int unsigned N_IRQ  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic              reg_priv_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              reg_err_o,
  input  logic              wfi_i,
  input  logic              wfe_i,
  input  logic              sev_i,
  input  logic              ext_evt_i,
  input  logic              handler_ret_i,
  input  logic [N_IRQ-1:0]  irq_pend_i,
  input  logic [N_IRQ-1:0]  irq_en_i,
  output logic              sleep_o,
  output logic              deep_o,
  output logic              wake_o
);
  lpw_ctrl_t ctrl;
  logic      irq_wake;
  logic      pend_evt;
  logic      evt;
  logic      evt_latch;

  lpw_ctrl_reg #(.DATA_W(DATA_W)) i_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .rd_i    (reg_rd_i),
    .priv_i  (reg_priv_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .err_o   (reg_err_o),
    .ctrl_o  (ctrl)
  );

  lpw_pend_detect #(.N_IRQ(N_IRQ)) i_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_i     (irq_pend_i),
    .en_i       (irq_en_i),
    .pend_evt_i (ctrl.pend_evt),
    .irq_wake_o (irq_wake),
    .pend_evt_o (pend_evt)
  );

  assign evt = sev_i || ext_evt_i || pend_evt;

  lpw_seq i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wfi_i      (wfi_i),
    .wfe_i      (wfe_i),
    .ret_i      (handler_ret_i),
    .exit_en_i  (ctrl.exit_slp),
    .deep_en_i  (ctrl.deep),
    .evt_i      (evt),
    .irq_wake_i (irq_wake),
    .sleep_o    (sleep_o),
    .deep_o     (deep_o),
    .wake_o     (wake_o),
    .latch_o    (evt_latch)
  );
endmodule

// File: rtl/lpw_checker.sv
module lpw_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic              reg_priv_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              reg_err_o,
  input logic              wfi_i,
  input logic              wfe_i,
  input logic              sleep_o,
  input logic              deep_o,
  input logic              wake_o,
  input logic [2:0]        ctrl_q,
  input logic              evt_latch
);
  localparam logic [DATA_W-1:0] FIELD_MASK = DATA_W'(32'h16);

  assert_reserved_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & ~FIELD_MASK) == '0);

  assert_unpriv_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !reg_priv_i) |=> $stable(ctrl_q));

  assert_unpriv_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && !reg_priv_i) |-> (reg_rdata_o == '0 && reg_err_o));

  assert_deep_in_sleep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deep_o |-> sleep_o);

  assert_latch_consume_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_latch && wfe_i && !wfi_i && !sleep_o) |=> (!sleep_o && !evt_latch));

  assert_wake_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  assert_wake_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !sleep_o);

  assert_wake_asleep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> sleep_o);
endmodule

bind lp_wake_ctrl lpw_checker #(.DATA_W(DATA_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_priv_i  (reg_priv_i),
  .reg_rdata_o (reg_rdata_o),
  .reg_err_o   (reg_err_o),
  .wfi_i       (wfi_i),
  .wfe_i       (wfe_i),
  .sleep_o     (sleep_o),
  .deep_o      (deep_o),
  .wake_o      (wake_o),
  .ctrl_q      (ctrl),
  .evt_latch   (evt_latch)
);

// File: tb/test_lp_wake_ctrl.sv
module test_lp_wake_ctrl;
  localparam int unsigned N_IRQ  = 32;
  localparam int unsigned DATA_W = 32;
  localparam time         PERIOD = 4ns;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0, reg_rd = 1'b0, reg_priv = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              reg_err;
  logic              wfi = 1'b0, wfe = 1'b0, sev = 1'b0, ext_evt = 1'b0, hret = 1'b0;
  logic [N_IRQ-1:0]  pend = '0, en = '0;
  logic              sleep, deep, wake;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [2:0] sdw;
  } exp_t;
  exp_t exp_q[$];
  exp_t cur;

  always #(PERIOD/2) clk = ~clk;

  lp_wake_ctrl #(.N_IRQ(N_IRQ), .DATA_W(DATA_W)) i_lp_wake_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_priv_i(reg_priv),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .reg_err_o(reg_err),
    .wfi_i(wfi), .wfe_i(wfe), .sev_i(sev), .ext_evt_i(ext_evt),
    .handler_ret_i(hret), .irq_pend_i(pend), .irq_en_i(en),
    .sleep_o(sleep), .deep_o(deep), .wake_o(wake)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare outputs after each edge against the queued expectation
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      chk(cur.tag, {29'd0, sleep, deep, wake}, {29'd0, cur.sdw});
    end
  end

  // driver: queue the outputs expected after the coming edge, then advance
  task automatic step(string tag, logic s, logic d, logic w);
    exp_t e;
    e.tag = tag;
    e.sdw = {s, d, w};
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic wr(logic priv, logic [DATA_W-1:0] data, string tag);
    reg_wr = 1'b1; reg_priv = priv; reg_wdata = data;
    step(tag, 0, 0, 0);
    reg_wr = 1'b0; reg_priv = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic priv, logic [31:0] exp_data, logic exp_err, string tag);
    reg_rd = 1'b1; reg_priv = priv;
    #1;
    chk({tag, " rdata"}, reg_rdata, exp_data);
    chk({tag, " err"}, {31'd0, reg_err}, {31'd0, exp_err});
    reg_rd = 1'b0; reg_priv = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step("R1 outputs after reset", 0, 0, 0);
    rd(1'b1, 32'h0, 1'b0, "R1 register after reset");

    // R2 field placement, reserved bits
    wr(1'b1, 32'hFFFF_FFFF, "R2 write all ones");
    rd(1'b1, 32'h16, 1'b0, "R2 only fields readable");

    // R3 privilege
    wr(1'b0, 32'h0, "R3 unpriv write");
    rd(1'b1, 32'h16, 1'b0, "R3 unpriv write ignored");
    rd(1'b0, 32'h0, 1'b1, "R3 unpriv read");
    wr(1'b1, 32'h0, "R2 clear");
    rd(1'b1, 32'h0, 1'b0, "R2 cleared");

    // R4/R5 wait-for-interrupt
    wfi = 1'b1; step("R4 wfi enters sleep", 1, 0, 0); wfi = 1'b0;
    sev = 1'b1; step("R5 event ignored by wfi", 1, 0, 0); sev = 1'b0;
    pend[3] = 1'b1; step("R5 disabled irq ignored", 1, 0, 0);
    en[5] = 1'b1; pend[5] = 1'b1;
    step("R5 enabled irq wakes", 1, 0, 1);
    step("R9 sleep drops after wake", 0, 0, 0);
    pend = '0; step("R5 idle", 0, 0, 0);

    // R8 event latched by the earlier sev
    wfe = 1'b1; step("R8 latched event consumed", 0, 0, 0); wfe = 1'b0;
    wfe = 1'b1; step("R8 next wfe sleeps", 1, 0, 0); wfe = 1'b0;
    ext_evt = 1'b1; step("R7 ext event wakes wfe", 1, 0, 1); ext_evt = 1'b0;
    step("R9 wake single cycle", 0, 0, 0);

    // R7 send-event and enabled interrupt wake wfe
    wfe = 1'b1; step("R7 wfe sleeps", 1, 0, 0); wfe = 1'b0;
    sev = 1'b1; step("R7 sev wakes wfe", 1, 0, 1); sev = 1'b0;
    step("R7 awake", 0, 0, 0);
    wfe = 1'b1; step("R7 wfe sleeps again", 1, 0, 0); wfe = 1'b0;
    pend[5] = 1'b1; step("R7 enabled irq wakes wfe", 1, 0, 1);
    step("R7 awake again", 0, 0, 0);

    // R10 level held does not wake; fall does not wake
    wfi = 1'b1; step("R10 wfi with pending held", 1, 0, 0); wfi = 1'b0;
    step("R10 held level no wake", 1, 0, 0);
    step("R10 held level no wake 2", 1, 0, 0);
    pend[5] = 1'b0; step("R10 falling edge no wake", 1, 0, 0);
    pend[5] = 1'b1; step("R10 new rise wakes", 1, 0, 1);
    step("R10 awake", 0, 0, 0);
    pend = '0; step("R10 idle", 0, 0, 0);

    // R6 pend-event: disabled interrupt wakes and raises an event
    wr(1'b1, 32'h10, "R6 set pend-event");
    wfi = 1'b1; step("R6 wfi sleeps", 1, 0, 0); wfi = 1'b0;
    pend[7] = 1'b1; step("R6 disabled irq wakes wfi", 1, 0, 1);
    step("R6 awake", 0, 0, 0);
    wfe = 1'b1; step("R6 pend event latched, wfe returns", 0, 0, 0); wfe = 1'b0;
    wfe = 1'b1; step("R6 wfe sleeps", 1, 0, 0); wfe = 1'b0;
    pend[9] = 1'b1; step("R6 disabled irq wakes wfe", 1, 0, 1);
    step("R6 awake after wfe", 0, 0, 0);
    pend = '0; step("R6 idle", 0, 0, 0);

    // R4 deep sleep
    wr(1'b1, 32'h04, "R4 set deep");
    wfi = 1'b1; step("R4 deep sleep", 1, 1, 0); wfi = 1'b0;
    pend[5] = 1'b1; step("R4 deep wake", 1, 1, 1);
    step("R9 deep drops after wake", 0, 0, 0);
    pend = '0; step("R4 idle", 0, 0, 0);

    // R11 sleep on return
    wr(1'b1, 32'h00, "R11 clear");
    hret = 1'b1; step("R11 return ignored when clear", 0, 0, 0); hret = 1'b0;
    wr(1'b1, 32'h02, "R11 set exit");
    hret = 1'b1; step("R11 return re-enters sleep", 1, 0, 0); hret = 1'b0;
    pend[5] = 1'b1; step("R11 irq wakes", 1, 0, 1);
    step("R11 awake", 0, 0, 0);
    pend = '0; step("R11 idle", 0, 0, 0);

    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule